// File: doc/BRIEF.md
# SMBus Host Block-Read Controller

This block is the host side of an SMBus controller, reduced to one transaction type: Block Read. Software programs it through a byte-wide register port. It loads the slave address and the command (offset) byte, selects the Block Read command type in the control register, and sets the start bit. The controller then collects the count byte and the data bytes from the bus side. It reports progress through a status register that software polls.

Data returns in one of two modes, chosen by an auxiliary control bit. In buffered mode the controller receives the whole block into a 32-entry buffer without stopping. Software then drains the buffer through the host block data register, and each read steps an internal pointer. In byte mode each data byte is placed in the host block data register and a byte-done flag is raised. The bus side holds off until software clears that flag by writing a 1 to it. A build parameter reproduces a known variant of byte mode in which the first data byte lands in data register 0 instead of the count.

A small bus-side byte source stands in for a slave device, so the block can be exercised on its own. The source sends the count taken from an input pin and then a data pattern derived from the command and address registers. It offers one byte every few cycles, and the controller takes it, ACKing or NACKing each byte.

Top module: `smbh_host`

## Requirements
- R1: After reset every register reads 0x00, and the status register (offset 0x0) reads 0x00.
- R2: While idle, the registers at 0x3 (command), 0x4 (slave address, bits 7:1 address, bit 0 read), 0x6 (data 1) and 0xD (auxiliary) read back the value written. The control register at 0x2 reads back bits 4:2 and bit 0, and bit 6 always reads 0.
- R3: A write to 0x2 with bit 6 = 1 and bits 4:2 = 3'b101 sets status bit 0 (busy) at the next clock edge. Any other command-type code does not start a transaction, and control bit 0 (interrupt enable) has no effect on a polled transfer.
- R4: In buffered mode (0xD bit 1 = 1), once all bytes are received, busy clears, status bit 1 (success) is set and data 0 (0x5) holds the count N.
- R5: Successive reads of 0x7 in buffered mode return data bytes in order, where byte k = (command + k) XOR {1'b0, address[7:1]}. Each read advances the pointer, and a new start resets it to byte 0.
- R6: A count of 0 or above 32 ends the transaction with status bit 2 (failure) set, bit 1 clear and busy clear. No data byte is taken.
- R7: In byte mode (0xD bit 1 = 0) each data byte appears in 0x7 with status bit 7 (byte done) set. No further bus byte is taken while bit 7 stays set.
- R8: In byte mode, writing 1 to status bit 7 clears it and releases the next byte. After the last byte is released, busy clears and bit 1 is set. Without the quirk, data 0 holds the count.
- R9: Status bits 1, 2 and 7 are write-one-to-clear, so writing back a value read from the status register clears every pending flag.
- R10: Software may end a byte-mode transfer early by writing 0x80 to the status register repeatedly until busy drops. The controller then finishes the bus transaction and returns to idle with bit 1 set.
- R11: Writes to 0x2, 0x3 and 0x4 while busy is set are ignored.
- R12: Per transaction the bus side takes the count byte plus N data bytes. It ACKs each byte except the last, which it NACKs (bus_nack_o high together with bus_take_o). For an invalid count, the count byte itself is NACKed.
- R13: With the quirk parameter set, in byte mode the first data byte goes to data 0 without raising byte done. From the second byte on, the data bytes come through 0x7 with byte done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (steps the buffer pointer on 0x7) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| slv_count | input | 8 | Count byte the modelled slave returns |
| bus_take_o | output | 1 | Pulse: controller accepts a byte from the bus side |
| bus_nack_o | output | 1 | With bus_take_o: the accepted byte is NACKed |

## Verification
Register writes land at the clock edge under the write strobe, and busy is already visible at the first sample point after the start edge. The bench therefore reads status straight after the start write. Bus bytes arrive every BYTE_CYCLES+1 cycles, so completion and byte-done are not due on a fixed cycle. The bench polls status with a bounded number of reads and flags a timeout as a failure. The stall is checked by holding byte done for twelve cycles and confirming at the falling edge that the count of bus takes did not move. Reads are combinational and sampled just after the falling edge, before the rising edge at which a 0x7 read steps the pointer.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam logic [3:0] RA_STAT = 4'h0;
  localparam logic [3:0] RA_CTL  = 4'h2;
  localparam logic [3:0] RA_CMD  = 4'h3;
  localparam logic [3:0] RA_ADDR = 4'h4;
  localparam logic [3:0] RA_D0   = 4'h5;
  localparam logic [3:0] RA_D1   = 4'h6;
  localparam logic [3:0] RA_HBD  = 4'h7;
  localparam logic [3:0] RA_AUX  = 4'hD;

  localparam logic [2:0] KIND_BLOCK = 3'b101;
  localparam logic [7:0] CTL_MASK   = 8'h1D;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CNT  = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/smbh_byte_src.sv
module smbh_byte_src #(
  parameter int BYTE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       take,
  input  logic       stop,
  input  logic [7:0] slv_count,
  input  logic [7:0] cmd,
  input  logic [6:0] addr7,
  output logic       valid,
  output logic [7:0] byte_o
);
  localparam int TW = $clog2(BYTE_CYCLES + 1);

  logic          act_q, act_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [7:0]    idx_q, idx_d;

  always_comb begin
    act_d = act_q;
    tmr_d = tmr_q;
    idx_d = idx_q;
    if (go) begin
      act_d = 1'b1;
      tmr_d = TW'(BYTE_CYCLES);
      idx_d = 8'd0;
    end else if (stop) begin
      act_d = 1'b0;
    end else if (take) begin
      tmr_d = TW'(BYTE_CYCLES);
      idx_d = idx_q + 8'd1;
    end else if (act_q && tmr_q != '0) begin
      tmr_d = tmr_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      tmr_q <= '0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      tmr_q <= tmr_d;
      idx_q <= idx_d;
    end
  end

  assign valid  = act_q && (tmr_q == '0);
  assign byte_o = (idx_q == 8'd0) ? slv_count
                                  : ((cmd + idx_q - 8'd1) ^ {1'b0, addr7});
endmodule

// File: rtl/smbh_buf.sv
module smbh_buf #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [7:0]               wdata,
  input  logic                     clr,
  input  logic                     adv,
  output logic [7:0]               rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (clr)      ptr_d = '0;
    else if (adv) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign rdata = mem[ptr_q];
endmodule

// File: rtl/smbh_ctrl.sv
module smbh_ctrl
  import smbh_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter bit QUIRK = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     buf_mode,
  input  logic [7:0]               w1c,
  input  logic                     src_valid,
  input  logic [7:0]               src_byte,
  output logic                     take,
  output logic                     nack,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic                     bdone,
  output logic                     d0_we,
  output logic                     hbd_we,
  output logic                     buf_we,
  output logic [$clog2(DEPTH)-1:0] buf_widx
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  ctl_state_e    st_q, st_d;
  logic [7:0]    cnt_q, cnt_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          mode_q, mode_d;
  logic          last_q, last_d;
  logic          done_q, err_q, bd_q;
  logic          fin, fail, set_bd, last;

  assign last = ((8'(idx_q) + 8'd1) == cnt_q);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    mode_d = mode_q;
    last_d = last_q;
    take   = 1'b0;
    nack   = 1'b0;
    d0_we  = 1'b0;
    hbd_we = 1'b0;
    buf_we = 1'b0;
    fin    = 1'b0;
    fail   = 1'b0;
    set_bd = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_CNT;
        mode_d = buf_mode;
        idx_d  = '0;
      end
      ST_CNT: if (src_valid) begin
        take = 1'b1;
        if (src_byte == 8'd0 || src_byte > 8'(DEPTH)) begin
          nack = 1'b1;
          fail = 1'b1;
          st_d = ST_IDLE;
        end else begin
          cnt_d = src_byte;
          d0_we = 1'b1;
          st_d  = ST_DATA;
        end
      end
      ST_DATA: if (src_valid) begin
        take  = 1'b1;
        nack  = last;
        idx_d = idx_q + CW'(1);
        if (mode_q) begin
          buf_we = 1'b1;
          if (last) begin fin = 1'b1; st_d = ST_IDLE; end
        end else if (QUIRK && idx_q == '0) begin
          d0_we = 1'b1;
          if (last) begin fin = 1'b1; st_d = ST_IDLE; end
        end else begin
          hbd_we = 1'b1;
          set_bd = 1'b1;
          last_d = last;
          st_d   = ST_HOLD;
        end
      end
      ST_HOLD: if (!bd_q) begin
        if (last_q) begin fin = 1'b1; st_d = ST_IDLE; end
        else        st_d = ST_DATA;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      mode_q <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      bd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      mode_q <= mode_d;
      last_q <= last_d;
      done_q <= start ? 1'b0 : (fin    | (done_q & ~w1c[1]));
      err_q  <= start ? 1'b0 : (fail   | (err_q  & ~w1c[2]));
      bd_q   <= start ? 1'b0 : (set_bd | (bd_q   & ~w1c[7]));
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign bdone    = bd_q;
  assign buf_widx = idx_q[AW-1:0];
endmodule

// File: rtl/smbh_host.sv
module smbh_host
  import smbh_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int BYTE_CYCLES = 4,
  parameter bit DAT0_FIRST  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] slv_count,
  output logic       bus_take_o,
  output logic       bus_nack_o
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic [7:0]    ctl_q, cmd_q, addr_q, d0_q, d1_q, hbd_q, aux_q;
  logic          busy, st_done, st_err, st_bdone;
  logic          start, d0_we, hbd_we, buf_we;
  logic [AW-1:0] buf_widx;
  logic [7:0]    buf_rdata, src_byte, w1c;
  logic          src_valid;
  logic          wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign wr_ok = reg_wr && !busy;
  assign start = wr_ok && (reg_addr == RA_CTL) && reg_wdata[6] &&
                 (reg_wdata[4:2] == KIND_BLOCK);
  assign w1c   = (reg_wr && reg_addr == RA_STAT) ? reg_wdata : 8'h00;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctl_q  <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      hbd_q  <= '0;
      aux_q  <= '0;
    end else begin
      if (wr_ok && reg_addr == RA_CTL)  ctl_q  <= reg_wdata & CTL_MASK;
      if (wr_ok && reg_addr == RA_CMD)  cmd_q  <= reg_wdata;
      if (wr_ok && reg_addr == RA_ADDR) addr_q <= reg_wdata;
      if (reg_wr && reg_addr == RA_D1)  d1_q   <= reg_wdata;
      if (reg_wr && reg_addr == RA_AUX) aux_q  <= reg_wdata;
      if (d0_we)                        d0_q   <= src_byte;
      else if (reg_wr && reg_addr == RA_D0) d0_q <= reg_wdata;
      if (hbd_we)                       hbd_q  <= src_byte;
    end
  end

  smbh_ctrl #(.DEPTH(DEPTH), .QUIRK(DAT0_FIRST)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .start(start), .buf_mode(aux_q[1]),
    .w1c(w1c), .src_valid(src_valid), .src_byte(src_byte),
    .take(bus_take_o), .nack(bus_nack_o), .busy(busy), .done(st_done),
    .err(st_err), .bdone(st_bdone), .d0_we(d0_we), .hbd_we(hbd_we),
    .buf_we(buf_we), .buf_widx(buf_widx)
  );

  smbh_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_i_n), .we(buf_we), .widx(buf_widx),
    .wdata(src_byte), .clr(start),
    .adv(reg_rd && reg_addr == RA_HBD && aux_q[1]),
    .rdata(buf_rdata)
  );

  smbh_byte_src #(.BYTE_CYCLES(BYTE_CYCLES)) u_src (
    .clk(clk), .rst_n(rst_i_n), .go(start), .take(bus_take_o),
    .stop(bus_take_o && bus_nack_o), .slv_count(slv_count),
    .cmd(cmd_q), .addr7(addr_q[7:1]), .valid(src_valid), .byte_o(src_byte)
  );

  always_comb begin
    case (reg_addr)
      RA_STAT: reg_rdata = {st_bdone, 4'b0000, st_err, st_done, busy};
      RA_CTL:  reg_rdata = ctl_q;
      RA_CMD:  reg_rdata = cmd_q;
      RA_ADDR: reg_rdata = addr_q;
      RA_D0:   reg_rdata = d0_q;
      RA_D1:   reg_rdata = d1_q;
      RA_HBD:  reg_rdata = aux_q[1] ? buf_rdata : hbd_q;
      RA_AUX:  reg_rdata = aux_q;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/smbh_host_chk.sv
module smbh_host_chk
  import smbh_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       bdone,
  input logic       done,
  input logic       err,
  input logic       take,
  input logic       nack,
  input logic [7:0] cmd_q
);
  // R3: a valid start while idle raises busy at the next edge
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_CTL && reg_wdata[6] &&
     reg_wdata[4:2] == KIND_BLOCK && !busy) |=> busy);

  // R7: no bus byte is taken while byte done is pending
  assert_bdone_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bdone |-> !take);

  // R8: byte done stays set until software writes 1 to bit 7
  assert_bdone_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bdone && !(reg_wr && reg_addr == RA_STAT && reg_wdata[7])) |=> bdone);

  // R11: command register frozen while busy
  assert_cmd_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));

  // R12: a NACK only accompanies an accepted byte
  assert_nack_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> take);

  // R6: a finished transaction reports exactly one of success or failure
  assert_end_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done != err));
endmodule

bind smbh_host smbh_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .bdone(st_bdone), .done(st_done),
  .err(st_err), .take(bus_take_o), .nack(bus_nack_o), .cmd_q(cmd_q)
);

// File: tb/sim_smbh_host.sv
`timescale 1ns/1ps
module sim_smbh_host;
  localparam logic [3:0] A_ST = 4'h0, A_CTL = 4'h2, A_CMD = 4'h3,
                         A_ADR = 4'h4, A_D0 = 4'h5, A_D1 = 4'h6,
                         A_HBD = 4'h7, A_AUX = 4'hD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] slv_count = 8'd0;
  logic [7:0] rdata0, rdata1;
  logic       take0, nack0, take1, nack1;

  int checks = 0, errors = 0;
  int takes = 0, nacks = 0;
  logic last_nack = 1'b0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  smbh_host u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata0),
    .slv_count(slv_count), .bus_take_o(take0), .bus_nack_o(nack0)
  );

  smbh_host #(.DAT0_FIRST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata1),
    .slv_count(slv_count), .bus_take_o(take1), .bus_nack_o(nack1)
  );

  always @(negedge clk) begin
    if (take0) begin
      takes <= takes + 1;
      if (nack0) nacks <= nacks + 1;
      last_nack <= nack0;
    end
  end

  function automatic logic [7:0] exp_byte(input logic [7:0] c,
                                          input logic [7:0] a, input int k);
    return (c + 8'(k)) ^ {1'b0, a[7:1]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = s ? rdata1 : rdata0;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_st(input logic s, input logic [7:0] mask,
                         input logic [7:0] val, output logic ok);
    logic [7:0] v;
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      rd(s, A_ST, v);
      if ((v & mask) == val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic drain();
    logic [7:0] a, b;
    for (int i = 0; i < 400; i++) begin
      wr(A_ST, 8'h80);
      rd(1'b0, A_ST, a);
      rd(1'b1, A_ST, b);
      if (!a[0] && !b[0]) break;
    end
    wr(A_ST, 8'hFF);
  endtask

  task automatic setup(input logic [7:0] aux, input logic [7:0] c,
                       input logic [7:0] a, input logic [7:0] n);
    drain();
    wr(A_AUX, aux);
    wr(A_CMD, c);
    wr(A_ADR, a);
    slv_count = n;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, A_ST, v);  chk("R1 status", v, 8'h00);
    rd(1'b0, A_CTL, v); chk("R1 control", v, 8'h00);
    rd(1'b0, A_CMD, v); chk("R1 command", v, 8'h00);
    rd(1'b0, A_AUX, v); chk("R1 aux", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(A_CMD, 8'h3A); rd(1'b0, A_CMD, v); chk("R2 command", v, 8'h3A);
    wr(A_ADR, 8'hA1); rd(1'b0, A_ADR, v); chk("R2 address", v, 8'hA1);
    wr(A_D1, 8'h5C);  rd(1'b0, A_D1, v);  chk("R2 data1", v, 8'h5C);
    wr(A_AUX, 8'h02); rd(1'b0, A_AUX, v); chk("R2 aux", v, 8'h02);
    wr(A_CTL, 8'hB5); rd(1'b0, A_CTL, v); chk("R2 control mask", v, 8'h15);
    rd(1'b0, A_ST, v); chk("R3 no start without bit6", v[0], 0);
  endtask

  task automatic t_kind();
    logic [7:0] v;
    setup(8'h02, 8'h10, 8'hA1, 8'd4);
    wr(A_CTL, 8'h49);
    rd(1'b0, A_ST, v); chk("R3 other kind no start", v[0], 0);
  endtask

  task automatic t_buf(input logic [7:0] c, input logic [7:0] a,
                       input int n, input logic [7:0] ctl);
    logic [7:0] v; logic ok; int t0, n0;
    setup(8'h02, c, a, 8'(n));
    t0 = takes; n0 = nacks;
    wr(A_CTL, ctl);
    rd(1'b0, A_ST, v); chk("R3 busy after start", v[0], 1);
    wait_st(1'b0, 8'h01, 8'h00, ok); chk("R4 completes", ok, 1);
    rd(1'b0, A_ST, v); chk("R4 status success", v, 8'h02);
    rd(1'b0, A_D0, v); chk("R4 data0 count", v, n);
    for (int k = 0; k < n; k++) begin
      rd(1'b0, A_HBD, v); chk($sformatf("R5 buffer byte %0d", k), v, exp_byte(c, a, k));
    end
    chk("R12 takes", takes - t0, n + 1);
    chk("R12 one nack", nacks - n0, 1);
    chk("R12 last nacked", last_nack, 1);
    wr(A_ST, 8'h02);
    rd(1'b0, A_ST, v); chk("R9 write-back clears", v, 8'h00);
  endtask

  task automatic t_ptr();
    logic [7:0] v; logic ok;
    setup(8'h02, 8'h40, 8'h22, 8'd6);
    wr(A_CTL, 8'h54);
    wait_st(1'b0, 8'h01, 8'h00, ok);
    rd(1'b0, A_HBD, v); rd(1'b0, A_HBD, v);
    chk("R5 pointer advanced", v, exp_byte(8'h40, 8'h22, 1));
    slv_count = 8'd3;
    wr(A_CTL, 8'h54);
    wait_st(1'b0, 8'h01, 8'h00, ok);
    rd(1'b0, A_HBD, v); chk("R5 pointer reset on start", v, exp_byte(8'h40, 8'h22, 0));
  endtask

  task automatic t_bad(input logic [7:0] n, input logic [7:0] aux);
    logic [7:0] v; logic ok; int t0, n0;
    setup(aux, 8'h05, 8'h31, n);
    t0 = takes; n0 = nacks;
    wr(A_CTL, 8'h54);
    wait_st(1'b0, 8'h01, 8'h00, ok); chk("R6 ends", ok, 1);
    rd(1'b0, A_ST, v); chk($sformatf("R6 failure flag count %0d", n), v, 8'h04);
    chk("R12 only count byte taken", takes - t0, 1);
    chk("R12 count byte nacked", nacks - n0, 1);
    wr(A_ST, v);
    rd(1'b0, A_ST, v); chk("R9 failure cleared", v, 8'h00);
  endtask

  task automatic t_byte(input logic [7:0] c, input logic [7:0] a, input int n);
    logic [7:0] v; logic ok; int t0, n0, tb;
    setup(8'h00, c, a, 8'(n));
    t0 = takes; n0 = nacks;
    wr(A_CTL, 8'h54);
    for (int k = 0; k < n; k++) begin
      wait_st(1'b0, 8'h80, 8'h80, ok); chk("R7 byte done raised", ok, 1);
      rd(1'b0, A_HBD, v); chk($sformatf("R7 byte %0d", k), v, exp_byte(c, a, k));
      tb = takes;
      repeat (12) @(negedge clk);
      chk("R7 stall while byte done", takes, tb);
      rd(1'b0, A_ST, v); chk("R8 still busy", v[0], 1);
      wr(A_ST, 8'h80);
    end
    wait_st(1'b0, 8'h01, 8'h00, ok); chk("R8 completes", ok, 1);
    rd(1'b0, A_ST, v); chk("R8 success", v, 8'h02);
    rd(1'b0, A_D0, v); chk("R8 data0 count", v, n);
    chk("R12 byte mode takes", takes - t0, n + 1);
    chk("R12 byte mode nack", nacks - n0, 1);
  endtask

  task automatic t_busy_wr();
    logic [7:0] v; logic ok;
    setup(8'h00, 8'h77, 8'h44, 8'd2);
    wr(A_CTL, 8'h54);
    wait_st(1'b0, 8'h80, 8'h80, ok);
    wr(A_CMD, 8'hEE); wr(A_ADR, 8'h10); wr(A_CTL, 8'h01);
    rd(1'b0, A_CMD, v); chk("R11 command held", v, 8'h77);
    rd(1'b0, A_ADR, v); chk("R11 address held", v, 8'h44);
    rd(1'b0, A_CTL, v); chk("R11 control held", v, 8'h14);
  endtask

  task automatic t_early();
    logic [7:0] v; logic ok; int t0;
    setup(8'h00, 8'h20, 8'h60, 8'd10);
    t0 = takes;
    wr(A_CTL, 8'h54);
    wait_st(1'b0, 8'h80, 8'h80, ok);
    wr(A_ST, 8'h80);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      wr(A_ST, 8'h80);
      rd(1'b0, A_ST, v);
      if (!v[0]) begin ok = 1'b1; break; end
    end
    chk("R10 busy drops", ok, 1);
    rd(1'b0, A_ST, v); chk("R10 idle with success", v, 8'h02);
    chk("R10 bus transaction finished", takes - t0, 11);
  endtask

  task automatic t_quirk();
    logic [7:0] v; logic ok;
    setup(8'h00, 8'h08, 8'h90, 8'd3);
    wr(A_CTL, 8'h54);
    wait_st(1'b1, 8'h80, 8'h80, ok); chk("R13 byte done", ok, 1);
    rd(1'b1, A_D0, v);  chk("R13 first byte in data0", v, exp_byte(8'h08, 8'h90, 0));
    rd(1'b1, A_HBD, v); chk("R13 second byte in block reg", v, exp_byte(8'h08, 8'h90, 1));
    wr(A_ST, 8'h80);
    wait_st(1'b1, 8'h80, 8'h80, ok);
    rd(1'b1, A_HBD, v); chk("R13 third byte", v, exp_byte(8'h08, 8'h90, 2));
    wr(A_ST, 8'h80);
    wait_st(1'b1, 8'h01, 8'h00, ok);
    rd(1'b1, A_ST, v); chk("R13 success", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_kind();
    t_buf(8'h10, 8'hA1, 5, 8'h55);
    t_buf(8'hF0, 8'h7F, 32, 8'h54);
    t_ptr();
    t_bad(8'd0, 8'h02);
    t_bad(8'd33, 8'h00);
    t_byte(8'h33, 8'h5B, 4);
    t_busy_wr();
    t_early();
    t_quirk();
    drain();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule